// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This block walks the transmit and receive descriptor rings of a simple Ethernet MAC. The rings live in a small internal table of descriptors. Each descriptor holds a 16-bit status/control word, a 16-bit length and a 32-bit buffer pointer. A host fills descriptors through a write port, reads them back through a read port, and uses a small register port to set the first table index of each ring, to ring a per-ring doorbell, to set the receive length limit and to clear completion events.

On the transmit side the engine offers each descriptor that the host has marked ready to a frame-source stub as a length and buffer pointer. When the stub reports completion with a retry count, the engine hands the slot back to the host. On the receive side the engine fills empty descriptors from a frame-sink stub that presents a length (CRC bytes included) and a 6-bit error vector. Each ring stops at the first descriptor it does not own and only resumes on the next doorbell. A descriptor carrying the wrap flag sends the ring back to its first index.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset every descriptor word reads as zero, both event outputs are low, `tx_valid` is low and `rx_ready` is low.
- R2: A transmit descriptor is offered only while its status bit 15 (ready) is set. On `tx_done` the engine clears bit 15, writes `tx_retry` into status bits 5:2 and keeps the other status bits.
- R3: While `tx_valid` is high and `tx_done` is low, `tx_valid`, `tx_len` and `tx_buf` hold steady.
- R4: A ring starts only on a register write of exactly 0x0100_0000 to its doorbell (address 2 for receive, address 3 for transmit). Any other value written there has no effect.
- R5: A ring that reaches a descriptor it does not own goes idle. It stays idle, even if the host then arms that descriptor, until the next valid doorbell.
- R6: After completing a descriptor with status bit 13 (wrap) set, the ring continues at its first index. That index is written at address 0 (receive) or address 1 (transmit) and defaults to 0.
- R7: A receive descriptor is filled only while status bit 15 (empty) is set. The engine stores `rx_len` unchanged, clears bit 15, sets bit 11 (last) and places `rx_err` in status bits 5:0.
- R8: A receive frame longer than the length limit (address 5, default 1520) is stored with the limit as its length and with status bit 5 set. A frame exactly at the limit is stored unchanged.
- R9: A completed frame sets the event of its ring (register bit 0 receive, bit 1 transmit, shown on `evt_rx` / `evt_tx`). Writing a one to that bit at address 4 clears it, and a completion in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| desc_we | input | 1 | Descriptor write strobe |
| desc_wr_idx | input | IW | Descriptor index to write |
| desc_wr_sel | input | 2 | Word select: 0 status, 1 length, 2 buffer pointer |
| desc_wdata | input | 32 | Descriptor write data |
| desc_rd_idx | input | IW | Descriptor index to read |
| desc_rd_sel | input | 2 | Word select for read |
| desc_rdata | output | 32 | Selected descriptor word (combinational) |
| evt_tx | output | 1 | Transmit completion event |
| evt_rx | output | 1 | Receive completion event |
| tx_valid | output | 1 | Transmit descriptor offered to frame source |
| tx_len | output | 16 | Length of offered transmit frame |
| tx_buf | output | 32 | Buffer pointer of offered transmit frame |
| tx_done | input | 1 | Frame source finished the offered frame |
| tx_retry | input | 4 | Retry count reported with `tx_done` |
| rx_ready | output | 1 | An empty receive descriptor is available |
| rx_valid | input | 1 | Frame sink presents a frame |
| rx_len | input | 16 | Received length including CRC |
| rx_err | input | 6 | Receive error flags |

## Verification
The bench builds the block with its defaults: eight descriptors and a 1520-byte receive limit. It splits the table into a three-entry receive ring at index 0 and a two-entry transmit ring at index 4, so both rings wrap after only a few frames and the return to a nonzero first index is visible. It then lowers the limit to 200 at run time, which puts both the truncated case and the exactly-at-limit case within reach with short lengths.

// File: rtl/bdre_pkg.sv
// Shared constants and types for the descriptor ring engine.
// Assumes a 16-bit status word, a 16-bit length and a 32-bit buffer pointer.
package bdre_pkg;
    localparam int STAT_W   = 16;
    localparam int LEN_W    = 16;
    localparam int PTR_W    = 32;
    localparam int OWN_BIT  = 15;   // ready (tx) / empty (rx)
    localparam int WRAP_BIT = 13;
    localparam int LAST_BIT = 11;
    localparam int ERR_W    = 6;
    localparam logic [31:0] KICK_VALUE = 32'h0100_0000;

    typedef enum logic {WALK_IDLE, WALK_RUN} walk_e;

    typedef enum logic [2:0] {
        REG_RX_BASE = 3'd0,
        REG_TX_BASE = 3'd1,
        REG_RX_KICK = 3'd2,
        REG_TX_KICK = 3'd3,
        REG_EVENT   = 3'd4,
        REG_MAX_LEN = 3'd5
    } reg_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [LEN_W-1:0]  len;
        logic [PTR_W-1:0]  buf_ptr;
    } desc_t;
endpackage

// File: rtl/bdre_desc_store.sv
// Descriptor table with one host write port and two engine write ports.
// Assumes the two rings occupy disjoint indices; on a same-index clash the
// receive engine wins over transmit, and both win over the host.
module bdre_desc_store
    import bdre_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IW = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IW-1:0]     host_idx,
    input  logic [1:0]        host_sel,
    input  logic [31:0]       host_wdata,
    input  logic              tx_we,
    input  logic [IW-1:0]     tx_idx,
    input  logic [STAT_W-1:0] tx_stat,
    input  logic              rx_we,
    input  logic [IW-1:0]     rx_idx,
    input  logic [STAT_W-1:0] rx_stat,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [IW-1:0]     tx_ridx,
    output desc_t             tx_rdesc,
    input  logic [IW-1:0]     rx_ridx,
    output logic [STAT_W-1:0] rx_rstat,
    input  logic [IW-1:0]     host_ridx,
    output desc_t             host_rdesc
);
    desc_t mem [NDESC];

    for (genvar e = 0; e < NDESC; e++) begin : g_ent
        desc_t ent_q;
        // Per-entry update with fixed write priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (rx_we && rx_idx == IW'(e)) begin
                ent_q.stat <= rx_stat;
                ent_q.len  <= rx_len;
            end else if (tx_we && tx_idx == IW'(e)) begin
                ent_q.stat <= tx_stat;
            end else if (host_we && host_idx == IW'(e)) begin
                case (host_sel)
                    2'd0:    ent_q.stat    <= host_wdata[STAT_W-1:0];
                    2'd1:    ent_q.len     <= host_wdata[LEN_W-1:0];
                    2'd2:    ent_q.buf_ptr <= host_wdata;
                    default: ;
                endcase
            end
        end
        assign mem[e] = ent_q;
    end

    assign tx_rdesc   = mem[tx_ridx];
    assign rx_rstat   = mem[rx_ridx].stat;
    assign host_rdesc = mem[host_ridx];

    // R2: a transmit completion hands the slot back to the host
    assert_tx_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_we && !(rx_we && rx_idx == tx_idx)) |=> !mem[$past(tx_idx)].stat[OWN_BIT]);
endmodule

// File: rtl/bdre_tx_walker.sv
// Transmit ring walker: after a doorbell it offers each ready descriptor to
// the frame source and writes back status on completion, stopping at the
// first descriptor it does not own. Assumes the host changes the first index
// only while the ring is idle.
module bdre_tx_walker
    import bdre_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IW = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic              base_we,
    input  logic [IW-1:0]     base_idx,
    input  desc_t             cur_desc,
    output logic [IW-1:0]     cur_idx,
    input  logic              tx_done,
    input  logic [3:0]        tx_retry,
    output logic              tx_valid,
    output logic [LEN_W-1:0]  tx_len,
    output logic [PTR_W-1:0]  tx_buf,
    output logic              wr_en,
    output logic [STAT_W-1:0] wr_stat,
    output logic              fire
);
    walk_e         state_q;
    logic [IW-1:0] base_q, cur_q, nxt_idx;
    logic          owned;

    assign owned    = cur_desc.stat[OWN_BIT];
    assign tx_valid = (state_q == WALK_RUN) && owned;
    assign tx_len   = cur_desc.len;
    assign tx_buf   = cur_desc.buf_ptr;
    assign fire     = tx_valid && tx_done;
    assign wr_en    = fire;
    assign cur_idx  = cur_q;

    // Build the write-back status: release ownership, record retries.
    always_comb begin
        wr_stat           = cur_desc.stat;
        wr_stat[OWN_BIT]  = 1'b0;
        wr_stat[5:2]      = tx_retry;
    end

    // Next slot: wrap to the first index, else step modulo the table size.
    assign nxt_idx = cur_desc.stat[WRAP_BIT] ? base_q :
                     (cur_q == IW'(NDESC-1)) ? '0 : cur_q + 1'b1;

    // Walk state and ring pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            base_q  <= '0;
            cur_q   <= '0;
        end else begin
            if (state_q == WALK_IDLE && kick)      state_q <= WALK_RUN;
            else if (state_q == WALK_RUN && !owned) state_q <= WALK_IDLE;
            if (base_we) begin
                base_q <= base_idx;
                cur_q  <= base_idx;
            end else if (fire) begin
                cur_q  <= nxt_idx;
            end
        end
    end

    // R5: without a doorbell an idle ring offers nothing next cycle
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WALK_IDLE && !kick) |=> !tx_valid);
    // R3: an offered frame holds until the source completes it
    assert_offer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_done && !base_we) |=> (tx_valid && $stable(tx_len) && $stable(tx_buf)));
endmodule

// File: rtl/bdre_rx_walker.sv
// Receive ring walker: after a doorbell it accepts frames into empty
// descriptors, clamps over-long frames to the programmed limit and stops at
// the first descriptor it does not own. Assumes the host changes the first
// index only while the ring is idle.
module bdre_rx_walker
    import bdre_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IW = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic              base_we,
    input  logic [IW-1:0]     base_idx,
    input  logic [LEN_W-1:0]  max_len,
    input  logic [STAT_W-1:0] cur_stat,
    output logic [IW-1:0]     cur_idx,
    output logic              rx_ready,
    input  logic              rx_valid,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [ERR_W-1:0]  rx_err,
    output logic              wr_en,
    output logic [STAT_W-1:0] wr_stat,
    output logic [LEN_W-1:0]  wr_len,
    output logic              fire
);
    walk_e            state_q;
    logic [IW-1:0]    base_q, cur_q, nxt_idx;
    logic             owned, too_long;
    logic [ERR_W-1:0] err_mix;

    assign owned    = cur_stat[OWN_BIT];
    assign rx_ready = (state_q == WALK_RUN) && owned;
    assign fire     = rx_ready && rx_valid;
    assign wr_en    = fire;
    assign cur_idx  = cur_q;
    assign too_long = rx_len > max_len;
    assign wr_len   = too_long ? max_len : rx_len;
    assign err_mix  = rx_err | {too_long, {(ERR_W-1){1'b0}}};

    // Write-back status: release, mark last, replace error field.
    always_comb begin
        wr_stat               = cur_stat;
        wr_stat[OWN_BIT]      = 1'b0;
        wr_stat[LAST_BIT]     = 1'b1;
        wr_stat[ERR_W-1:0]    = err_mix;
    end

    // Next slot: wrap to the first index, else step modulo the table size.
    assign nxt_idx = cur_stat[WRAP_BIT] ? base_q :
                     (cur_q == IW'(NDESC-1)) ? '0 : cur_q + 1'b1;

    // Walk state and ring pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            base_q  <= '0;
            cur_q   <= '0;
        end else begin
            if (state_q == WALK_IDLE && kick)      state_q <= WALK_RUN;
            else if (state_q == WALK_RUN && !owned) state_q <= WALK_IDLE;
            if (base_we) begin
                base_q <= base_idx;
                cur_q  <= base_idx;
            end else if (fire) begin
                cur_q  <= nxt_idx;
            end
        end
    end

    // R8: a stored length never exceeds the limit
    assert_len_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_len <= max_len));
    // R5: without a doorbell an idle ring accepts nothing next cycle
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WALK_IDLE && !kick) |=> !rx_ready);
endmodule

// File: rtl/bd_ring_engine.sv
// Top of the descriptor ring engine: register port (first indices, doorbells,
// length limit, events), descriptor table and the two ring walkers.
// Assumes the host keeps the two rings on disjoint table indices.
module bd_ring_engine
    import bdre_pkg::*;
#(
    parameter int NDESC       = 8,
    parameter int MAX_LEN_DEF = 1520,
    localparam int IW = $clog2(NDESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          desc_we,
    input  logic [IW-1:0] desc_wr_idx,
    input  logic [1:0]    desc_wr_sel,
    input  logic [31:0]   desc_wdata,
    input  logic [IW-1:0] desc_rd_idx,
    input  logic [1:0]    desc_rd_sel,
    output logic [31:0]   desc_rdata,
    output logic          evt_tx,
    output logic          evt_rx,
    output logic          tx_valid,
    output logic [15:0]   tx_len,
    output logic [31:0]   tx_buf,
    input  logic          tx_done,
    input  logic [3:0]    tx_retry,
    output logic          rx_ready,
    input  logic          rx_valid,
    input  logic [15:0]   rx_len,
    input  logic [5:0]    rx_err
);
    logic [LEN_W-1:0]  max_q;
    logic [1:0]        evt_q;
    logic              tx_kick, rx_kick, tx_base_we, rx_base_we, evt_clr;
    logic              tx_we, rx_we, tx_fire, rx_fire;
    logic [IW-1:0]     tx_idx, rx_idx;
    logic [STAT_W-1:0] tx_wstat, rx_wstat, rx_cur_stat;
    logic [LEN_W-1:0]  rx_wlen;
    desc_t             tx_cur, host_desc;

    assign tx_kick    = cfg_we && cfg_addr == REG_TX_KICK && cfg_wdata == KICK_VALUE;
    assign rx_kick    = cfg_we && cfg_addr == REG_RX_KICK && cfg_wdata == KICK_VALUE;
    assign tx_base_we = cfg_we && cfg_addr == REG_TX_BASE;
    assign rx_base_we = cfg_we && cfg_addr == REG_RX_BASE;
    assign evt_clr    = cfg_we && cfg_addr == REG_EVENT;

    // Length limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  max_q <= LEN_W'(MAX_LEN_DEF);
        else if (cfg_we && cfg_addr == REG_MAX_LEN) max_q <= cfg_wdata[LEN_W-1:0];
    end

    // Completion events: set on completion, write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q[0] <= rx_fire | (evt_q[0] & ~(evt_clr & cfg_wdata[0]));
            evt_q[1] <= tx_fire | (evt_q[1] & ~(evt_clr & cfg_wdata[1]));
        end
    end

    assign evt_rx = evt_q[0];
    assign evt_tx = evt_q[1];

    // Host read mux over the selected descriptor word.
    always_comb begin
        case (desc_rd_sel)
            2'd0:    desc_rdata = {16'b0, host_desc.stat};
            2'd1:    desc_rdata = {16'b0, host_desc.len};
            2'd2:    desc_rdata = host_desc.buf_ptr;
            default: desc_rdata = '0;
        endcase
    end

    bdre_desc_store #(.NDESC(NDESC)) u_store (
        .clk(clk), .rst_n(rst_n),
        .host_we(desc_we), .host_idx(desc_wr_idx), .host_sel(desc_wr_sel), .host_wdata(desc_wdata),
        .tx_we(tx_we), .tx_idx(tx_idx), .tx_stat(tx_wstat),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_stat(rx_wstat), .rx_len(rx_wlen),
        .tx_ridx(tx_idx), .tx_rdesc(tx_cur),
        .rx_ridx(rx_idx), .rx_rstat(rx_cur_stat),
        .host_ridx(desc_rd_idx), .host_rdesc(host_desc)
    );

    bdre_tx_walker #(.NDESC(NDESC)) u_tx (
        .clk(clk), .rst_n(rst_n), .kick(tx_kick),
        .base_we(tx_base_we), .base_idx(cfg_wdata[IW-1:0]),
        .cur_desc(tx_cur), .cur_idx(tx_idx),
        .tx_done(tx_done), .tx_retry(tx_retry),
        .tx_valid(tx_valid), .tx_len(tx_len), .tx_buf(tx_buf),
        .wr_en(tx_we), .wr_stat(tx_wstat), .fire(tx_fire)
    );

    bdre_rx_walker #(.NDESC(NDESC)) u_rx (
        .clk(clk), .rst_n(rst_n), .kick(rx_kick),
        .base_we(rx_base_we), .base_idx(cfg_wdata[IW-1:0]), .max_len(max_q),
        .cur_stat(rx_cur_stat), .cur_idx(rx_idx),
        .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_len(rx_len), .rx_err(rx_err),
        .wr_en(rx_we), .wr_stat(rx_wstat), .wr_len(rx_wlen), .fire(rx_fire)
    );

    // R9: a transmit completion always leaves its event set
    assert_evt_tx_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |=> evt_tx);
    // R9: a receive completion always leaves its event set
    assert_evt_rx_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fire |=> evt_rx);
endmodule

// File: tb/bd_ring_engine_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module bd_ring_engine_bench;
    localparam int NDESC = 8;
    localparam int IW    = $clog2(NDESC);

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cfg_we = 0, desc_we = 0, tx_done = 0, rx_valid = 0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0, desc_wdata = '0, desc_rdata, tx_buf;
    logic [IW-1:0] desc_wr_idx = '0, desc_rd_idx = '0;
    logic [1:0]    desc_wr_sel = '0, desc_rd_sel = '0;
    logic          evt_tx, evt_rx, tx_valid, rx_ready;
    logic [15:0]   tx_len, rx_len = '0;
    logic [3:0]    tx_retry = '0;
    logic [5:0]    rx_err = '0;
    int            total = 0, bad = 0;
    bit            finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    bd_ring_engine u_bd_ring_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .desc_we(desc_we), .desc_wr_idx(desc_wr_idx), .desc_wr_sel(desc_wr_sel), .desc_wdata(desc_wdata),
        .desc_rd_idx(desc_rd_idx), .desc_rd_sel(desc_rd_sel), .desc_rdata(desc_rdata),
        .evt_tx(evt_tx), .evt_rx(evt_rx), .tx_valid(tx_valid), .tx_len(tx_len), .tx_buf(tx_buf),
        .tx_done(tx_done), .tx_retry(tx_retry), .rx_ready(rx_ready), .rx_valid(rx_valid),
        .rx_len(rx_len), .rx_err(rx_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic desc_wr(input int idx, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); desc_we = 1; desc_wr_idx = IW'(idx); desc_wr_sel = sel; desc_wdata = d;
        @(negedge clk); desc_we = 0;
    endtask

    task automatic peek(input int idx, input logic [1:0] sel, output logic [31:0] v);
        desc_rd_idx = IW'(idx); desc_rd_sel = sel; #1; v = desc_rdata;
    endtask

    task automatic tx_finish(input logic [3:0] r);
        tx_done = 1; tx_retry = r;
        @(negedge clk); tx_done = 0;
    endtask

    task automatic rx_frame(input logic [15:0] l, input logic [5:0] e);
        rx_valid = 1; rx_len = l; rx_err = e;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 evt_tx", evt_tx, 0);
        chk("R1 evt_rx", evt_rx, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 rx_ready", rx_ready, 0);
        peek(3, 0, v); chk("R1 status zero", v, 0);
        peek(6, 2, v); chk("R1 pointer zero", v, 0);
    endtask

    task automatic t_tx_basic;
        logic [31:0] v;
        cfg_wr(3'd1, 4);                        // R10-style map: tx first index = 4
        desc_wr(4, 1, 100); desc_wr(4, 2, 32'h1000); desc_wr(4, 0, 32'h8800);
        desc_wr(5, 0, 32'h2000);                 // wrap, not ready
        cfg_wr(3'd3, 32'h0100_0000);
        chk("R4 tx offered after doorbell", tx_valid, 1);
        chk("R2 tx_len", tx_len, 100);
        chk("R2 tx_buf", tx_buf, 32'h1000);
        repeat (2) @(negedge clk);
        chk("R3 offer held", {tx_valid, tx_len}, {1'b1, 16'd100});
        tx_finish(4'd3);
        peek(4, 0, v); chk("R2 status after send", v, 32'h080C);
        chk("R9 evt_tx set", evt_tx, 1);
        chk("R5 stops at unowned slot", tx_valid, 0);
    endtask

    task automatic t_tx_kick_and_wrap;
        logic [31:0] v;
        desc_wr(5, 1, 60); desc_wr(5, 2, 32'h2000); desc_wr(5, 0, 32'hA800);
        cfg_wr(3'd3, 32'h0000_0001);
        repeat (3) @(negedge clk);
        chk("R4 wrong doorbell value ignored", tx_valid, 0);
        cfg_wr(3'd2, 32'h0100_0000);             // rx doorbell does not start tx
        chk("R4 other ring doorbell ignored", tx_valid, 0);
        cfg_wr(3'd3, 32'h0100_0000);
        chk("R4 tx_len slot5", {tx_valid, tx_len}, {1'b1, 16'd60});
        tx_finish(4'd0);
        peek(5, 0, v); chk("R6 wrap slot status", v, 32'h2800);
        chk("R5 idle at released first slot", tx_valid, 0);
        desc_wr(4, 1, 77); desc_wr(4, 0, 32'h8800);
        repeat (3) @(negedge clk);
        chk("R5 no poll without doorbell", tx_valid, 0);
        cfg_wr(3'd3, 32'h0100_0000);
        chk("R6 wrapped to first index", {tx_valid, tx_len}, {1'b1, 16'd77});
        tx_finish(4'd15);
        peek(4, 0, v); chk("R2 retry field max", v, 32'h083C);
    endtask

    task automatic t_rx;
        logic [31:0] v;
        cfg_wr(3'd0, 0);
        desc_wr(0, 0, 32'h8000); desc_wr(1, 0, 32'h8000); desc_wr(2, 0, 32'hA000);
        chk("R5 rx idle before doorbell", rx_ready, 0);
        cfg_wr(3'd2, 32'h0100_0000);
        chk("R7 rx ready", rx_ready, 1);
        rx_frame(64, 0);
        peek(0, 1, v); chk("R7 length incl CRC", v, 64);
        peek(0, 0, v); chk("R7 good status", v, 32'h0800);
        chk("R9 evt_rx set", evt_rx, 1);
        rx_frame(90, 6'h04);
        peek(1, 0, v); chk("R7 error flags", v, 32'h0804);
        rx_frame(2000, 0);
        peek(2, 1, v); chk("R8 clamped to 1520", v, 1520);
        peek(2, 0, v); chk("R8 overlength flag", v, 32'h2820);
        chk("R6 rx wrapped to filled slot and stopped", rx_ready, 0);
    endtask

    task automatic t_rx_limit;
        logic [31:0] v;
        cfg_wr(3'd5, 200);
        desc_wr(0, 0, 32'h8000); desc_wr(1, 0, 32'h8000);
        cfg_wr(3'd2, 32'h0100_0000);
        rx_frame(300, 0);
        peek(0, 1, v); chk("R8 clamped to new limit", v, 200);
        peek(0, 0, v); chk("R8 flag new limit", v, 32'h0820);
        rx_frame(200, 0);
        peek(1, 1, v); chk("R8 at limit kept", v, 200);
        peek(1, 0, v); chk("R8 at limit no flag", v, 32'h0800);
    endtask

    task automatic t_events;
        cfg_wr(3'd4, 2);
        chk("R9 tx cleared", evt_tx, 0);
        chk("R9 rx kept", evt_rx, 1);
        cfg_wr(3'd4, 1);
        chk("R9 rx cleared", evt_rx, 0);
        // completion and clear in the same cycle: set wins
        desc_wr(2, 0, 32'hA000);
        cfg_wr(3'd2, 32'h0100_0000);
        @(negedge clk);
        rx_valid = 1; rx_len = 70; rx_err = 0;
        cfg_we = 1; cfg_addr = 3'd4; cfg_wdata = 1;
        @(negedge clk); rx_valid = 0; cfg_we = 0;
        chk("R9 set wins over clear", evt_rx, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_tx_basic;
        t_tx_kick_and_wrap;
        t_rx;
        t_rx_limit;
        t_events;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule